// File: doc/BRIEF.md
# Memory Access Ordering Queue

This block keeps memory loads and stores in order in a machine where integer and floating-point instructions are issued separately. Address generation on the integer side feeds it; floating-point loads are the only path by which the two streams depend on each other. It takes the place of a load reservation station. Pending loads sit in one small in-order queue and pending stores in another. Each entry carries a wrap-around age stamp from the front end, plus an address that may arrive with the entry or later through an update port.

Each cycle the oldest load and the oldest store are each tested for release toward memory. A load may leave only if no older store is still pending with the same address or with an address not yet known. This prevents read-after-write hazards. A store may leave only if no older load or store is pending with the same or an unknown address. This prevents write-after-read and write-after-write hazards. Both queues drain strictly in the order entries were accepted, at most one load and one store per cycle. The memory itself and address generation are outside the block.

Top module: `memq_guard`

## Requirements
- R1: After reset neither release output is asserted and both enqueue-ready outputs are high.
- R2: The load queue holds DEPTH entries (default 4). Once DEPTH loads are pending, `ld_enq_ready` is low, and a load presented while it is low is dropped: it is never released.
- R3: Loads are released one per cycle at most, in the order they were accepted. A head load whose address is unknown holds back every younger load.
- R4: A load at the head with a known address and no conflict is released in the first cycle after the clock edge that made it so. The release outputs depend only on registered state.
- R5: A load is held while an older pending store has the same address, and it is released the cycle after that store leaves.
- R6: A load is held while an older pending store has no known address yet.
- R7: A store younger than a load never holds that load, even when the two addresses are equal.
- R8: A store is held while an older pending load has the same address or an unknown address.
- R9: The store queue holds DEPTH entries and releases in acceptance order, one per cycle at most. `st_enq_ready` is low while it is full, and a store presented then is dropped.
- R10: An address update (`upd_store` = 1 selects the store queue, 0 the load queue) fills in the address of the entry in that queue whose age stamp matches and whose address is still unknown. An update whose stamp matches no such entry in the chosen queue has no effect.
- R11: Age stamp a is older than b when the AGE_W-bit difference a − b has its top bit set, so order is kept across wrap-around (stamp 31 is older than stamp 0 for AGE_W = 5).
- R12: One load and one store that do not conflict are released in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_enq_valid | input | 1 | Load entry presented |
| ld_enq_age | input | AGE_W | Age stamp of the presented load |
| ld_enq_known | input | 1 | Load address is valid at enqueue |
| ld_enq_addr | input | ADDR_W | Load address |
| ld_enq_ready | output | 1 | Load queue can accept an entry |
| st_enq_valid | input | 1 | Store entry presented |
| st_enq_age | input | AGE_W | Age stamp of the presented store |
| st_enq_known | input | 1 | Store address is valid at enqueue |
| st_enq_addr | input | ADDR_W | Store address |
| st_enq_ready | output | 1 | Store queue can accept an entry |
| upd_valid | input | 1 | Late address update presented |
| upd_store | input | 1 | Update targets the store queue (1) or the load queue (0) |
| upd_age | input | AGE_W | Age stamp of the entry to update |
| upd_addr | input | ADDR_W | Address to fill in |
| ld_rel_valid | output | 1 | A load is released this cycle |
| ld_rel_age | output | AGE_W | Age stamp of the released load |
| ld_rel_addr | output | ADDR_W | Address of the released load |
| st_rel_valid | output | 1 | A store is released this cycle |
| st_rel_age | output | AGE_W | Age stamp of the released store |
| st_rel_addr | output | ADDR_W | Address of the released store |

## Verification
The bench builds chains of dependences. An unresolved older load pins a store, which in turn must pin a younger load with the same address. A design that tested only equal addresses, and ignored unknown ones, would let that store or load out early. A design that ignored age would hold a load behind a younger store. Age stamps are also placed across the wrap point, where a plain unsigned compare inverts the order and lets a load pass an older unresolved store. Further cases cover full queues that must drop the extra entry, and updates aimed at the wrong queue or at a stamp that matches no entry, which must leave every entry untouched.

// File: rtl/mq_pkg.sv
package mq_pkg;
    parameter int AGE_W  = 5;
    parameter int ADDR_W = 16;

    typedef struct packed {
        logic              vld;
        logic [AGE_W-1:0]  age;
        logic              known;
        logic [ADDR_W-1:0] addr;
    } mq_entry_t;

    // a is older than b when the modular difference is negative
    function automatic logic is_older(input logic [AGE_W-1:0] a,
                                      input logic [AGE_W-1:0] b);
        logic [AGE_W-1:0] diff;
        diff = a - b;
        return diff[AGE_W-1];
    endfunction
endpackage

// File: rtl/mq_queue.sv
module mq_queue
    import mq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enq_valid,
    input  logic [AGE_W-1:0]        enq_age,
    input  logic                    enq_known,
    input  logic [ADDR_W-1:0]       enq_addr,
    output logic                    enq_ready,
    input  logic                    upd_valid,
    input  logic [AGE_W-1:0]        upd_age,
    input  logic [ADDR_W-1:0]       upd_addr,
    input  logic                    deq,
    output mq_entry_t [DEPTH-1:0]   ents,
    output mq_entry_t               head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        mq_entry_t [DEPTH-1:0] ent;
        logic [PW-1:0]         hd;
        logic [PW-1:0]         tl;
        logic [CW-1:0]         cnt;
    } q_state_t;

    q_state_t s_d, s_q;
    logic     enq_fire;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign enq_ready = (s_q.cnt != CW'(DEPTH));
    assign enq_fire  = enq_valid && enq_ready;
    assign ents      = s_q.ent;
    assign head      = s_q.ent[s_q.hd];

    always_comb begin
        s_d = s_q;
        // late address fill for an entry still waiting on its address
        for (int i = 0; i < DEPTH; i++) begin
            if (upd_valid && s_q.ent[i].vld && !s_q.ent[i].known &&
                s_q.ent[i].age == upd_age) begin
                s_d.ent[i].known = 1'b1;
                s_d.ent[i].addr  = upd_addr;
            end
        end
        if (deq) begin
            s_d.ent[s_q.hd].vld = 1'b0;
            s_d.hd              = ptr_next(s_q.hd);
        end
        if (enq_fire) begin
            s_d.ent[s_q.tl].vld   = 1'b1;
            s_d.ent[s_q.tl].age   = enq_age;
            s_d.ent[s_q.tl].known = enq_known;
            s_d.ent[s_q.tl].addr  = enq_addr;
            s_d.tl                = ptr_next(s_q.tl);
        end
        case ({enq_fire, deq})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/mq_conflict.sv
module mq_conflict
    import mq_pkg::*;
#(
    parameter int N = 4
) (
    input  mq_entry_t           cand,
    input  mq_entry_t [N-1:0]   others,
    output logic                block
);
    logic [N-1:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = others[g].vld &&
                        is_older(others[g].age, cand.age) &&
                        (!others[g].known || (others[g].addr == cand.addr));
    end

    assign block = |hit;
endmodule

// File: rtl/memq_guard.sv
module memq_guard
    import mq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_enq_valid,
    input  logic [AGE_W-1:0]  ld_enq_age,
    input  logic              ld_enq_known,
    input  logic [ADDR_W-1:0] ld_enq_addr,
    output logic              ld_enq_ready,
    input  logic              st_enq_valid,
    input  logic [AGE_W-1:0]  st_enq_age,
    input  logic              st_enq_known,
    input  logic [ADDR_W-1:0] st_enq_addr,
    output logic              st_enq_ready,
    input  logic              upd_valid,
    input  logic              upd_store,
    input  logic [AGE_W-1:0]  upd_age,
    input  logic [ADDR_W-1:0] upd_addr,
    output logic              ld_rel_valid,
    output logic [AGE_W-1:0]  ld_rel_age,
    output logic [ADDR_W-1:0] ld_rel_addr,
    output logic              st_rel_valid,
    output logic [AGE_W-1:0]  st_rel_age,
    output logic [ADDR_W-1:0] st_rel_addr
);
    mq_entry_t [DEPTH-1:0] ld_ents, st_ents;
    mq_entry_t             ld_head, st_head;
    logic                  ld_blk_by_st, st_blk_by_ld, st_blk_by_st;
    logic                  ld_go, st_go;

    mq_queue #(.DEPTH(DEPTH)) u_ldq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_valid (ld_enq_valid),
        .enq_age   (ld_enq_age),
        .enq_known (ld_enq_known),
        .enq_addr  (ld_enq_addr),
        .enq_ready (ld_enq_ready),
        .upd_valid (upd_valid && !upd_store),
        .upd_age   (upd_age),
        .upd_addr  (upd_addr),
        .deq       (ld_go),
        .ents      (ld_ents),
        .head      (ld_head)
    );

    mq_queue #(.DEPTH(DEPTH)) u_stq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_valid (st_enq_valid),
        .enq_age   (st_enq_age),
        .enq_known (st_enq_known),
        .enq_addr  (st_enq_addr),
        .enq_ready (st_enq_ready),
        .upd_valid (upd_valid && upd_store),
        .upd_age   (upd_age),
        .upd_addr  (upd_addr),
        .deq       (st_go),
        .ents      (st_ents),
        .head      (st_head)
    );

    // read-after-write: head load against all stores
    mq_conflict #(.N(DEPTH)) u_ld_vs_st (
        .cand   (ld_head),
        .others (st_ents),
        .block  (ld_blk_by_st)
    );

    // write-after-read: head store against all loads
    mq_conflict #(.N(DEPTH)) u_st_vs_ld (
        .cand   (st_head),
        .others (ld_ents),
        .block  (st_blk_by_ld)
    );

    // write-after-write: head store against the other stores
    mq_conflict #(.N(DEPTH)) u_st_vs_st (
        .cand   (st_head),
        .others (st_ents),
        .block  (st_blk_by_st)
    );

    assign ld_go = ld_head.vld && ld_head.known && !ld_blk_by_st;
    assign st_go = st_head.vld && st_head.known && !st_blk_by_ld && !st_blk_by_st;

    assign ld_rel_valid = ld_go;
    assign ld_rel_age   = ld_head.age;
    assign ld_rel_addr  = ld_head.addr;
    assign st_rel_valid = st_go;
    assign st_rel_age   = st_head.age;
    assign st_rel_addr  = st_head.addr;
endmodule

// File: rtl/memq_guard_chk.sv
module memq_guard_chk
    import mq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_enq_valid,
    input logic              ld_enq_ready,
    input logic              st_enq_valid,
    input logic              st_enq_ready,
    input logic              ld_rel_valid,
    input logic [AGE_W-1:0]  ld_rel_age,
    input logic [ADDR_W-1:0] ld_rel_addr,
    input logic              st_rel_valid,
    input logic [AGE_W-1:0]  st_rel_age,
    input logic [ADDR_W-1:0] st_rel_addr
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] ld_pend, st_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_pend <= '0;
            st_pend <= '0;
        end else begin
            ld_pend <= ld_pend + CW'(ld_enq_valid && ld_enq_ready) - CW'(ld_rel_valid);
            st_pend <= st_pend + CW'(st_enq_valid && st_enq_ready) - CW'(st_rel_valid);
        end
    end

    // R2
    ld_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_enq_ready == (ld_pend != CW'(DEPTH)));

    // R9
    st_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_enq_ready == (st_pend != CW'(DEPTH)));

    // R3
    ld_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pend == '0) |-> !ld_rel_valid);

    // R9
    st_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_pend == '0) |-> !st_rel_valid);

    // R5
    same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_rel_valid && st_rel_valid) |-> (ld_rel_addr != st_rel_addr));

    // R3
    ld_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rel_valid |=> (!ld_rel_valid || ld_rel_age != $past(ld_rel_age)));

    // R9
    st_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_rel_valid |=> (!st_rel_valid || st_rel_age != $past(st_rel_age)));
endmodule

bind memq_guard memq_guard_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/memq_guard_bench.sv
module memq_guard_bench;
    import mq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_enq_valid = 1'b0, ld_enq_known = 1'b0, ld_enq_ready;
    logic [AGE_W-1:0]  ld_enq_age = '0;
    logic [ADDR_W-1:0] ld_enq_addr = '0;
    logic              st_enq_valid = 1'b0, st_enq_known = 1'b0, st_enq_ready;
    logic [AGE_W-1:0]  st_enq_age = '0;
    logic [ADDR_W-1:0] st_enq_addr = '0;
    logic              upd_valid = 1'b0, upd_store = 1'b0;
    logic [AGE_W-1:0]  upd_age = '0;
    logic [ADDR_W-1:0] upd_addr = '0;
    logic              ld_rel_valid, st_rel_valid;
    logic [AGE_W-1:0]  ld_rel_age, st_rel_age;
    logic [ADDR_W-1:0] ld_rel_addr, st_rel_addr;

    memq_guard #(.DEPTH(DEPTH)) u_memq_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_enq_valid (ld_enq_valid),
        .ld_enq_age   (ld_enq_age),
        .ld_enq_known (ld_enq_known),
        .ld_enq_addr  (ld_enq_addr),
        .ld_enq_ready (ld_enq_ready),
        .st_enq_valid (st_enq_valid),
        .st_enq_age   (st_enq_age),
        .st_enq_known (st_enq_known),
        .st_enq_addr  (st_enq_addr),
        .st_enq_ready (st_enq_ready),
        .upd_valid    (upd_valid),
        .upd_store    (upd_store),
        .upd_age      (upd_age),
        .upd_addr     (upd_addr),
        .ld_rel_valid (ld_rel_valid),
        .ld_rel_age   (ld_rel_age),
        .ld_rel_addr  (ld_rel_addr),
        .st_rel_valid (st_rel_valid),
        .st_rel_age   (st_rel_age),
        .st_rel_addr  (st_rel_addr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [AGE_W-1:0] age_ctr = '0;

    int ld_n = 0, st_n = 0;
    int ld_cyc [64];
    int ld_age [64];
    int ld_adr [64];
    int st_cyc [64];
    int st_age [64];

    always @(posedge clk) cyc <= cyc + 1;

    // release log, taken mid-cycle when outputs are settled
    always @(negedge clk) begin
        if (rst_n) begin
            if (ld_rel_valid && ld_n < 64) begin
                ld_cyc[ld_n] = cyc;
                ld_age[ld_n] = int'(ld_rel_age);
                ld_adr[ld_n] = int'(ld_rel_addr);
                ld_n++;
            end
            if (st_rel_valid && st_n < 64) begin
                st_cyc[st_n] = cyc;
                st_age[st_n] = int'(st_rel_age);
                st_n++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_log();
        ld_n = 0;
        st_n = 0;
    endtask

    task automatic enq_ld(input int addr, input bit known, output int age_o);
        ld_enq_valid = 1'b1;
        ld_enq_age   = age_ctr;
        ld_enq_known = known;
        ld_enq_addr  = ADDR_W'(addr);
        age_o        = int'(age_ctr);
        age_ctr      = age_ctr + 1'b1;
        step();
        ld_enq_valid = 1'b0;
    endtask

    task automatic enq_st(input int addr, input bit known, output int age_o);
        st_enq_valid = 1'b1;
        st_enq_age   = age_ctr;
        st_enq_known = known;
        st_enq_addr  = ADDR_W'(addr);
        age_o        = int'(age_ctr);
        age_ctr      = age_ctr + 1'b1;
        step();
        st_enq_valid = 1'b0;
    endtask

    task automatic upd(input bit is_st, input int age, input int addr, output int e);
        upd_valid = 1'b1;
        upd_store = is_st;
        upd_age   = AGE_W'(age);
        upd_addr  = ADDR_W'(addr);
        step();
        e = cyc;
        upd_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ld_rel_valid", int'(ld_rel_valid), 0);
        chk("R1 st_rel_valid", int'(st_rel_valid), 0);
        chk("R1 ld_enq_ready", int'(ld_enq_ready), 1);
        chk("R1 st_enq_ready", int'(st_enq_ready), 1);
    endtask

    task automatic t_simple_load();
        int a, e;
        clear_log();
        enq_ld(16'h0123, 1'b1, a);
        e = cyc;
        idle(3);
        chk("R4 release count", ld_n, 1);
        chk("R4 release cycle", ld_cyc[0], e);
        chk("R4 release addr", ld_adr[0], 16'h0123);
        chk("R4 release age", ld_age[0], a);
    endtask

    task automatic t_raw_war();
        int a0, s0, a1, e;
        clear_log();
        enq_ld(0, 1'b0, a0);
        enq_st(16'h0040, 1'b1, s0);
        enq_ld(16'h0040, 1'b1, a1);
        idle(2);
        chk("R8 store held by unknown older load", st_n, 0);
        chk("R3 loads held behind unknown head", ld_n, 0);
        upd(1'b0, a0, 16'h0040, e);
        idle(5);
        chk("R10 first load released on update", ld_cyc[0], e);
        chk("R8 store waits for older same-addr load", st_cyc[0], e + 1);
        chk("R5 load waits for older same-addr store", ld_cyc[1], e + 2);
        chk("R5 second load age", ld_age[1], a1);
    endtask

    task automatic t_unknown_store();
        int s1, l2, e;
        clear_log();
        enq_st(0, 1'b0, s1);
        enq_ld(16'h0010, 1'b1, l2);
        idle(3);
        chk("R6 load held by unknown older store", ld_n, 0);
        upd(1'b1, s1, 16'h0020, e);
        idle(3);
        chk("R12 store released", st_cyc[0], e);
        chk("R12 load released same cycle", ld_cyc[0], e);
    endtask

    task automatic t_young_store();
        int la, sa, e;
        clear_log();
        ld_enq_valid = 1'b1; ld_enq_age = age_ctr; ld_enq_known = 1'b1; ld_enq_addr = 16'h0060;
        la = int'(age_ctr); age_ctr = age_ctr + 1'b1;
        st_enq_valid = 1'b1; st_enq_age = age_ctr; st_enq_known = 1'b1; st_enq_addr = 16'h0060;
        sa = int'(age_ctr); age_ctr = age_ctr + 1'b1;
        step();
        e = cyc;
        ld_enq_valid = 1'b0;
        st_enq_valid = 1'b0;
        idle(3);
        chk("R7 load not held by younger store", ld_cyc[0], e);
        chk("R8 store held by older load", st_cyc[0], e + 1);
        chk("R8 store age", st_age[0], sa);
        chk("R7 load age", ld_age[0], la);
    endtask

    task automatic t_order();
        int a5, a6, a7, e, d;
        clear_log();
        enq_ld(0, 1'b0, a5);
        enq_ld(16'h0070, 1'b1, a6);
        enq_ld(16'h0071, 1'b1, a7);
        idle(2);
        upd(1'b0, a5 + 9, 16'h0011, d);
        upd(1'b1, a5, 16'h0011, d);
        idle(2);
        chk("R10 mismatched update has no effect", ld_n, 0);
        upd(1'b0, a5, 16'h0072, e);
        idle(5);
        chk("R3 count", ld_n, 3);
        chk("R3 first", ld_age[0], a5);
        chk("R10 updated address used", ld_adr[0], 16'h0072);
        chk("R3 second age", ld_age[1], a6);
        chk("R3 second cycle", ld_cyc[1], e + 1);
        chk("R3 third age", ld_age[2], a7);
        chk("R3 third cycle", ld_cyc[2], e + 2);
    endtask

    task automatic t_load_full();
        int b [4];
        int e, bad;
        clear_log();
        for (int i = 0; i < 4; i++) enq_ld(0, 1'b0, b[i]);
        chk("R2 ready low when full", int'(ld_enq_ready), 0);
        enq_ld(16'h0099, 1'b1, bad);
        for (int i = 0; i < 4; i++) upd(1'b0, b[i], 16'h00A0 + i, e);
        idle(4);
        chk("R2 only accepted loads released", ld_n, 4);
        for (int i = 0; i < 4; i++) chk("R2 order", ld_age[i], b[i]);
        chk("R2 ready back", int'(ld_enq_ready), 1);
    endtask

    task automatic t_store_full();
        int l, e, bad;
        int s [4];
        clear_log();
        enq_ld(0, 1'b0, l);
        for (int i = 0; i < 4; i++) enq_st(16'h00B0 + i, 1'b1, s[i]);
        chk("R9 ready low when full", int'(st_enq_ready), 0);
        enq_st(16'h00BF, 1'b1, bad);
        upd(1'b0, l, 16'h00F0, e);
        idle(6);
        chk("R9 store count", st_n, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R9 store order", st_age[i], s[i]);
            chk("R9 one store per cycle", st_cyc[i], e + i);
        end
    endtask

    task automatic t_wrap();
        int sa, la, e;
        clear_log();
        age_ctr = AGE_W'(31);
        enq_st(0, 1'b0, sa);
        enq_ld(16'h0090, 1'b1, la);
        idle(3);
        chk("R11 load held by store older across wrap", ld_n, 0);
        upd(1'b1, sa, 16'h0090, e);
        idle(3);
        chk("R11 store released", st_cyc[0], e);
        chk("R11 load after store", ld_cyc[0], e + 1);
        chk("R11 load age", ld_age[0], la);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_simple_load();   idle(4);
        t_raw_war();       idle(4);
        t_unknown_store(); idle(4);
        t_young_store();   idle(4);
        t_order();         idle(4);
        t_load_full();     idle(4);
        t_store_full();    idle(4);
        t_wrap();          idle(4);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule